// File: doc/BRIEF.md
# Matrix Tile Reorder Buffer

This block sits in front of (or behind) a blocked matrix-multiply engine and changes the order in which the elements of one matrix travel. In tiling mode it takes a plain stream of elements and emits them tile by tile. In detiling mode it takes a tiled stream and emits it in plain order. A whole matrix is collected in one half of a two-slot internal store. The matrix is then read back through an address walker, while the other slot can already be filled with the next matrix.

The matrix size is fixed by parameters. The tile height and width, the plain-side orientation (rows first or columns first) and the direction (tile or detile) are run-time inputs. They are captured with the first element of each matrix. A configuration whose tile does not divide the matrix evenly is flagged, and no new matrix starts while it is present. Both edges are valid/ready streams.

Top module: `mtx_tile_reorder`

## Requirements
- R1: After reset, with a legal configuration, `in_ready` is 1, `out_valid` is 0 and `cfg_err` is 0.
- R2: In tiling mode the output visits the tiles left to right within a tile row, tile rows top to bottom, and inside a tile it goes row by row, left to right. With a 16x16 matrix whose element at row r, column c carries value 16r+c, and 4x4 tiles, the output starts 0,1,2,3,16,17,18,19,32,33,34,35,48,49,50,51,4,5,6,7,20,21.
- R3: The tile heights and widths of 2 and 4 are supported in all four pairings (h x w = 4x4, 4x2, 2x4, 2x2). With 4-row, 2-column tiles on the 16x16 matrix, the output starts 0,1,16,17,32,33,48,49,2,3,18,19 and ends 238,239,254,255.
- R4: When `cfg_col_major` is 1 in tiling mode, the input arrives column by column (row index varying fastest), and the tiles are formed on the row-major view of the matrix.
- R5: When `cfg_detile` is 1, the input is taken in the tiled order of R2 and the output is plain order. It is row-major with `cfg_col_major`=0 and column-major with `cfg_col_major`=1.
- R6: The configuration is sampled with the first accepted element of a matrix. Changes to it while the rest of that matrix is streaming have no effect on that matrix.
- R7: While one matrix is held unread, a second matrix is accepted. When both slots hold complete matrices, `in_ready` is 0.
- R8: `cfg_err` is 1 whenever a tile dimension is zero, larger than the matrix, or does not divide the matching matrix dimension. While it is 1, no first element of a new matrix is accepted (`in_ready` is 0).
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` is unchanged at the next cycle.
- R10: `out_valid` becomes 1 in the cycle after the final element of a matrix is accepted, when no earlier matrix is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_detile | input | 1 | 0: plain in, tiled out; 1: tiled in, plain out |
| cfg_col_major | input | 1 | Plain-side order is columns first |
| cfg_tile_h | input | DIM_W | Tile height in rows |
| cfg_tile_w | input | DIM_W | Tile width in columns |
| in_valid | input | 1 | Input element present |
| in_ready | output | 1 | Input element can be taken |
| in_data | input | DATA_W | Input element |
| out_valid | output | 1 | Output element present |
| out_ready | input | 1 | Consumer takes output element |
| out_data | output | DATA_W | Output element |
| cfg_err | output | 1 | Current tile configuration is illegal |

## Verification
The final input handshake of a matrix marks its slot full at that clock edge, so the first reordered element is due one cycle later. Each further element follows in the cycle after each output handshake. The bench drives at falling edges and samples `out_valid`, `out_data`, `in_ready` and `cfg_err` at falling edges, half a period after the edge that updated them. A scoreboard queue, filled by the driver from the tile formulas, is compared on each falling edge where a handshake is due. The latency check waits exactly one falling edge after the last input handshake. The full-slot and error checks are taken on the first falling edge after the stimulus has settled.

// File: rtl/mtr_pkg.sv
package mtr_pkg;

    parameter int unsigned DIM_W = 6;

    typedef logic [DIM_W-1:0] dim_t;

    typedef struct packed {
        logic detile;
        logic col_major;
        dim_t tile_h;
        dim_t tile_w;
    } mtr_cfg_t;

    typedef struct packed {
        dim_t h;
        dim_t w;
    } walk_shape_t;

    function automatic logic cfg_ok(mtr_cfg_t c, int unsigned rows, int unsigned cols);
        int unsigned h;
        int unsigned w;
        h = int'(c.tile_h);
        w = int'(c.tile_w);
        if (h == 0 || w == 0) return 1'b0;
        if (h > rows || w > cols) return 1'b0;
        return ((rows % h) == 0) && ((cols % w) == 0);
    endfunction

    // Plain order is a degenerate tile walk: 1 x cols for rows first,
    // rows x 1 for columns first.
    function automatic walk_shape_t shape_for(mtr_cfg_t c, logic tiled,
                                              int unsigned rows, int unsigned cols);
        walk_shape_t s;
        if (tiled) begin
            s.h = c.tile_h;
            s.w = c.tile_w;
        end else if (c.col_major) begin
            s.h = dim_t'(rows);
            s.w = dim_t'(1);
        end else begin
            s.h = dim_t'(1);
            s.w = dim_t'(cols);
        end
        return s;
    endfunction

endpackage

// File: rtl/mtr_walker.sv
module mtr_walker
    import mtr_pkg::*;
#(
    parameter int unsigned ROWS = 16,
    parameter int unsigned COLS = 16,
    parameter int unsigned AW   = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  walk_shape_t shape,
    input  logic        advance,
    output logic [AW-1:0] addr,
    output logic        last
);

    localparam logic [DIM_W:0] ROWS_L = (DIM_W+1)'(ROWS);
    localparam logic [DIM_W:0] COLS_L = (DIM_W+1)'(COLS);

    dim_t rb, cb, ir, ic;
    logic [DIM_W:0] rb_nxt, cb_nxt, row_sum, col_sum;
    logic ic_end, ir_end, cb_end, rb_end;

    always_comb begin
        rb_nxt  = {1'b0, rb} + {1'b0, shape.h};
        cb_nxt  = {1'b0, cb} + {1'b0, shape.w};
        row_sum = {1'b0, rb} + {1'b0, ir};
        col_sum = {1'b0, cb} + {1'b0, ic};
        ic_end  = (ic == shape.w - 1'b1);
        ir_end  = (ir == shape.h - 1'b1);
        cb_end  = (cb_nxt == COLS_L);
        rb_end  = (rb_nxt == ROWS_L);
        last    = ic_end && ir_end && cb_end && rb_end;
        addr    = AW'(32'(row_sum) * COLS + 32'(col_sum));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rb <= '0;
            cb <= '0;
            ir <= '0;
            ic <= '0;
        end else if (advance) begin
            if (!ic_end) begin
                ic <= ic + 1'b1;
            end else begin
                ic <= '0;
                if (!ir_end) begin
                    ir <= ir + 1'b1;
                end else begin
                    ir <= '0;
                    if (!cb_end) begin
                        cb <= cb_nxt[DIM_W-1:0];
                    end else begin
                        cb <= '0;
                        rb <= rb_end ? '0 : rb_nxt[DIM_W-1:0];
                    end
                end
            end
        end
    end

    // R2
    walk_range_chk: assert property (@(posedge clk) disable iff (rst)
        (row_sum < ROWS_L) && (col_sum < COLS_L));

    // R2
    walk_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (advance && last) |=> (addr == '0));

endmodule

// File: rtl/mtr_store.sv
module mtr_store #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned AW     = 9
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int unsigned DEPTH = 1 << AW;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/mtx_tile_reorder.sv
module mtx_tile_reorder
    import mtr_pkg::*;
#(
    parameter int unsigned ROWS   = 16,
    parameter int unsigned COLS   = 16,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_detile,
    input  logic              cfg_col_major,
    input  logic [DIM_W-1:0]  cfg_tile_h,
    input  logic [DIM_W-1:0]  cfg_tile_w,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              cfg_err
);

    localparam int unsigned ELEMS = ROWS * COLS;
    localparam int unsigned AW    = (ELEMS > 1) ? $clog2(ELEMS) : 1;

    mtr_cfg_t    live_cfg, wr_cfg, rd_cfg;
    mtr_cfg_t    cfg_q [2];
    walk_shape_t wr_shape, rd_shape;
    logic [1:0]  full, full_n;
    logic        wr_sel, rd_sel, wr_busy;
    logic        in_fire, out_fire, wr_last, rd_last;
    logic [AW-1:0] wr_addr, rd_addr;

    always_comb begin
        live_cfg = '{detile: cfg_detile, col_major: cfg_col_major,
                     tile_h: cfg_tile_h, tile_w: cfg_tile_w};
        cfg_err  = !cfg_ok(live_cfg, ROWS, COLS);
        wr_cfg   = wr_busy ? cfg_q[wr_sel] : live_cfg;
        rd_cfg   = cfg_q[rd_sel];
        wr_shape = shape_for(wr_cfg, wr_cfg.detile, ROWS, COLS);
        rd_shape = shape_for(rd_cfg, !rd_cfg.detile, ROWS, COLS);
        in_ready = !full[wr_sel] && (wr_busy || !cfg_err);
        out_valid = full[rd_sel];
        in_fire  = in_valid && in_ready;
        out_fire = out_valid && out_ready;
        full_n   = full;
        if (in_fire && wr_last)   full_n[wr_sel] = 1'b1;
        if (out_fire && rd_last)  full_n[rd_sel] = 1'b0;
    end

    mtr_walker #(.ROWS(ROWS), .COLS(COLS), .AW(AW)) wr_walk_i (
        .clk(clk), .rst(rst), .shape(wr_shape), .advance(in_fire),
        .addr(wr_addr), .last(wr_last)
    );

    mtr_walker #(.ROWS(ROWS), .COLS(COLS), .AW(AW)) rd_walk_i (
        .clk(clk), .rst(rst), .shape(rd_shape), .advance(out_fire),
        .addr(rd_addr), .last(rd_last)
    );

    mtr_store #(.DATA_W(DATA_W), .AW(AW + 1)) store_i (
        .clk(clk), .we(in_fire),
        .waddr({wr_sel, wr_addr}), .wdata(in_data),
        .raddr({rd_sel, rd_addr}), .rdata(out_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            full    <= '0;
            wr_sel  <= 1'b0;
            rd_sel  <= 1'b0;
            wr_busy <= 1'b0;
            for (int i = 0; i < 2; i++) cfg_q[i] <= '0;
        end else begin
            full <= full_n;
            if (in_fire) begin
                if (!wr_busy) cfg_q[wr_sel] <= live_cfg;
                if (wr_last) begin
                    wr_busy <= 1'b0;
                    wr_sel  <= ~wr_sel;
                end else begin
                    wr_busy <= 1'b1;
                end
            end
            if (out_fire && rd_last) rd_sel <= ~rd_sel;
        end
    end

    // R7
    both_full_block_chk: assert property (@(posedge clk) disable iff (rst)
        (&full) |-> !in_ready);

    // R8
    no_start_on_err_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && !wr_busy) |-> !cfg_err);

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R10
    handoff_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (in_fire && wr_last) |=> out_valid);

endmodule

// File: tb/mtx_tile_reorder_tb_top.sv
`timescale 1ns/1ps
module mtx_tile_reorder_tb_top;
    import mtr_pkg::*;

    localparam int R = 16;
    localparam int C = 16;
    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_detile = 1'b0, cfg_col_major = 1'b0;
    logic [DIM_W-1:0] cfg_tile_h = DIM_W'(4), cfg_tile_w = DIM_W'(4);
    logic in_valid = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic out_ready = 1'b0;
    logic in_ready, out_valid, cfg_err;
    logic [DW-1:0] out_data;

    int errors = 0;
    int checks = 0;
    int exp_q[$];
    string tag_q[$];
    bit stall = 1'b0;
    int cyc = 0;
    int mat_id = 0;

    always #2.5 clk = ~clk;

    mtx_tile_reorder #(.ROWS(R), .COLS(C), .DATA_W(DW)) dut_i (
        .clk(clk), .rst(rst),
        .cfg_detile(cfg_detile), .cfg_col_major(cfg_col_major),
        .cfg_tile_h(cfg_tile_h), .cfg_tile_w(cfg_tile_w),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .cfg_err(cfg_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // value of the k-th element in tiled order (value = 16*row + col)
    function automatic int tile_val(int k, int h, int w);
        int tpr, t, e, r, c;
        tpr = C / w;
        t = k / (h * w);
        e = k % (h * w);
        r = (t / tpr) * h + e / w;
        c = (t % tpr) * w + e % w;
        return r * C + c;
    endfunction

    function automatic int plain_val(int k, bit cm);
        if (cm) return (k % R) * C + (k / R);
        return k;
    endfunction

    task automatic send_matrix(input bit det, input bit cm, input int h, input int w,
                               input bit scramble, input string req);
        int base;
        base = mat_id * 256;
        mat_id++;
        @(negedge clk);
        cfg_detile = det;
        cfg_col_major = cm;
        cfg_tile_h = DIM_W'(h);
        cfg_tile_w = DIM_W'(w);
        for (int k = 0; k < R * C; k++) begin
            exp_q.push_back((base + (det ? plain_val(k, cm) : tile_val(k, h, w))) & 16'hFFFF);
            tag_q.push_back(req);
        end
        for (int k = 0; k < R * C; k++) begin
            if (k > 0) @(negedge clk);
            if (scramble && k == 1) begin
                cfg_col_major = ~cm;
                cfg_tile_h = DIM_W'(2);
                cfg_tile_w = DIM_W'(2);
            end
            in_valid = 1'b1;
            in_data = DW'(base + (det ? tile_val(k, h, w) : plain_val(k, cm)));
            while (!in_ready) @(negedge clk);
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // monitor / scoreboard
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (rst) begin
                out_ready = 1'b0;
            end else begin
                out_ready = !stall && ((cyc % 5) != 3);
                if (out_valid && out_ready) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R2 unexpected output", int'(out_data), -1);
                    end else begin
                        int e;
                        string t;
                        e = exp_q.pop_front();
                        t = tag_q.pop_front();
                        check(int'(out_data) == e, t, int'(out_data), e);
                    end
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
        check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
        check(cfg_err == 1'b0, "R1 cfg_err", int'(cfg_err), 0);

        send_matrix(0, 0, 4, 4, 0, "R2");
        send_matrix(0, 0, 4, 2, 0, "R3");
        send_matrix(0, 0, 2, 4, 0, "R3");
        send_matrix(0, 0, 2, 2, 0, "R3");
        send_matrix(0, 1, 4, 4, 0, "R4");
        send_matrix(0, 1, 2, 4, 0, "R4");
        send_matrix(1, 0, 4, 2, 0, "R5");
        send_matrix(1, 1, 4, 4, 0, "R5");
        send_matrix(0, 0, 4, 4, 1, "R6");
        drain();

        // R7 / R10: consumer stalled, two matrices fit, third is held off
        stall = 1'b1;
        @(negedge clk);
        send_matrix(0, 0, 2, 2, 0, "R7");
        check(out_valid == 1'b1, "R10 out_valid after last input", int'(out_valid), 1);
        send_matrix(1, 1, 2, 4, 0, "R7");
        check(in_ready == 1'b0, "R7 in_ready with both slots full", int'(in_ready), 0);
        check(out_valid == 1'b1, "R9 out_valid held during stall", int'(out_valid), 1);
        check(int'(out_data) == (mat_id - 2) * 256, "R9 out_data held during stall",
              int'(out_data), (mat_id - 2) * 256);
        stall = 1'b0;
        drain();

        // R8: illegal tile configurations
        cfg_detile = 1'b0;
        cfg_col_major = 1'b0;
        cfg_tile_h = DIM_W'(3);
        cfg_tile_w = DIM_W'(4);
        @(negedge clk);
        check(cfg_err == 1'b1, "R8 cfg_err h=3", int'(cfg_err), 1);
        check(in_ready == 1'b0, "R8 in_ready h=3", int'(in_ready), 0);
        in_valid = 1'b1;
        in_data = 16'hBEEF;
        repeat (5) @(negedge clk);
        in_valid = 1'b0;
        check(out_valid == 1'b0, "R8 nothing accepted", int'(out_valid), 0);
        cfg_tile_h = DIM_W'(0);
        @(negedge clk);
        check(cfg_err == 1'b1, "R8 cfg_err h=0", int'(cfg_err), 1);
        cfg_tile_h = DIM_W'(4);
        cfg_tile_w = DIM_W'(5);
        @(negedge clk);
        check(cfg_err == 1'b1, "R8 cfg_err w=5", int'(cfg_err), 1);
        cfg_tile_w = DIM_W'(32);
        @(negedge clk);
        check(cfg_err == 1'b1, "R8 cfg_err w=32", int'(cfg_err), 1);
        cfg_tile_w = DIM_W'(2);
        @(negedge clk);
        check(cfg_err == 1'b0, "R8 cfg_err cleared", int'(cfg_err), 0);
        check(in_ready == 1'b1, "R8 in_ready restored", int'(in_ready), 1);
        send_matrix(0, 0, 4, 2, 0, "R8");
        drain();

        finish_run();
    end

endmodule